// File: doc/BRIEF.md
# System Reset Control Port

This block is a one-byte register that sits on an I/O bus at a single fixed port address. Platform firmware writes it to choose what kind of reset the platform should perform and to ask for a reset. It can read the chosen kind back.

A write with the trigger bit set produces a one-cycle reset request pulse. That write does not touch the stored byte. Any other write to the port keeps only the reset-type bit, so every other bit of the register always reads as zero.

Accesses to any other address are ignored. While such an access is in progress the read data bus is not driven.

Top module: `sysrst_ctrl`

## Requirements
- R1: Only accesses at port address 0xCF9 reach the register. A write to any other address, including 0xCF8 and 0xCFA, leaves the stored byte unchanged.
- R2: A write to the port with bit 2 (trigger) set issues a reset request and leaves the stored byte unchanged.
- R3: A write to the port with bit 2 clear stores bit 1 (reset type) of the write data and forces all other stored bits to zero.
- R4: A read at the port returns the stored byte in the same cycle, so only bit 1 can read back as one.
- R5: While the synchronous reset input is high, the stored byte clears to 0x00 on the clock edge and no reset request is issued. If reset and a write occur together, reset wins.
- R6: `sys_rst_req` goes high for exactly one cycle, in the clock cycle after the qualifying write. Trigger writes on consecutive cycles give consecutive pulses.
- R7: Reads, writes to the port with bit 2 clear, and accesses to other addresses never issue a reset request.
- R8: `io_rdata_en` is high only during a read at the port. Whenever it is low, `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_rdata | output | 8 | Read data, 0x00 when not selected |
| io_rdata_en | output | 1 | Read data drive enable |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The assertions check the following on every cycle:
- A trigger write keeps the stored byte stable.
- A write to the port with bit 2 clear stores only the type bit.
- Non-port cycles leave the register alone.
- Every request pulse traces back to a trigger write in the previous cycle.
- The read bus stays quiet when it is not enabled.

Only the bench's scenarios can show the rest:
- Read-back values seen through the bus after long random mixes of port and near-miss addresses.
- Reset colliding with a write.
- Back-to-back trigger writes producing back-to-back pulses.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int TRIG_BIT = 2;
    localparam int TYPE_BIT = 1;

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } store_state_t;

    typedef struct packed {
        logic req;
    } pulse_state_t;
endpackage

// File: rtl/sysrst_decode.sv
module sysrst_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9,
    parameter int              TRIG_BIT  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    output logic              rd_hit,
    output logic              wr_store,
    output logic              wr_trig
);
    logic hit;

    always_comb begin
        hit      = (addr == PORT_ADDR);
        rd_hit   = hit && rd;
        wr_trig  = hit && wr && wdata[TRIG_BIT];
        wr_store = hit && wr && !wdata[TRIG_BIT];
    end
endmodule

// File: rtl/sysrst_store.sv
module sysrst_store
    import sysrst_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int TYPE_BIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_store,
    input  logic              wr_trig,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] val
);
    localparam logic [DATA_W-1:0] TYPE_MASK = DATA_W'(1) << TYPE_BIT;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.val = '0;
        end else if (wr_store) begin
            st_d.val = wdata & TYPE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign val = st_q.val;

    AST_TRIG_KEEPS_VALUE: assert property (@(posedge clk) disable iff (rst)
        wr_trig |=> $stable(st_q.val)); // R2
    AST_STORE_TYPE_ONLY: assert property (@(posedge clk) disable iff (rst)
        wr_store |=> (st_q.val == ($past(wdata) & TYPE_MASK))); // R3
    AST_IDLE_KEEPS_VALUE: assert property (@(posedge clk) disable iff (rst)
        (!wr_store && !wr_trig) |=> $stable(st_q.val)); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (st_q.val == '0)); // R5
endmodule

// File: rtl/sysrst_pulse.sv
module sysrst_pulse
    import sysrst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_trig,
    output logic req
);
    pulse_state_t pl_d, pl_q;

    always_comb begin
        pl_d.req = wr_trig && !rst;
    end

    always_ff @(posedge clk) begin
        pl_q <= pl_d;
    end

    assign req = pl_q.req;

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        req |-> $past(wr_trig)); // R6
    AST_NO_SPURIOUS_REQ: assert property (@(posedge clk) disable iff (rst)
        !wr_trig |=> !req); // R7
    AST_REQ_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !req); // R5
endmodule

// File: rtl/sysrst_ctrl.sv
module sysrst_ctrl
    import sysrst_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    output logic [DATA_W-1:0] io_rdata,
    output logic              io_rdata_en,
    output logic              sys_rst_req
);
    logic              rd_hit;
    logic              wr_store;
    logic              wr_trig;
    logic [DATA_W-1:0] val;

    sysrst_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_ADDR(PORT_ADDR),
        .TRIG_BIT (TRIG_BIT)
    ) u_decode (
        .addr    (io_addr),
        .wdata   (io_wdata),
        .rd      (io_rd),
        .wr      (io_wr),
        .rd_hit  (rd_hit),
        .wr_store(wr_store),
        .wr_trig (wr_trig)
    );

    sysrst_store #(
        .DATA_W  (DATA_W),
        .TYPE_BIT(TYPE_BIT)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_store(wr_store),
        .wr_trig (wr_trig),
        .wdata   (io_wdata),
        .val     (val)
    );

    sysrst_pulse u_pulse (
        .clk    (clk),
        .rst    (rst),
        .wr_trig(wr_trig),
        .req    (sys_rst_req)
    );

    always_comb begin
        io_rdata_en = rd_hit;
        io_rdata    = rd_hit ? val : '0;
    end

    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !io_rdata_en |-> (io_rdata == '0)); // R8
    AST_RDATA_TYPE_ONLY: assert property (@(posedge clk) disable iff (rst)
        io_rdata_en |-> ((io_rdata & ~(DATA_W'(1) << TYPE_BIT)) == '0)); // R4
endmodule

// File: tb/sysrst_ctrl_tb.sv
module sysrst_ctrl_tb_top;
    localparam logic [15:0] PORT = 16'hCF9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic        io_rdata_en;
    logic        sys_rst_req;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_store = '0;
    logic       m_trig  = 1'b0;

    always #10 clk = ~clk;

    sysrst_ctrl dut_i (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
        .io_rdata_en(io_rdata_en), .sys_rst_req(sys_rst_req)
    );

    function automatic logic [7:0] exp_rdata(logic [15:0] a, logic r, logic [7:0] s);
        return (r && a == PORT) ? s : 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic r, input logic [15:0] a, input logic [7:0] d,
                        input logic rd, input logic wr);
        @(negedge clk);
        rst = r; io_addr = a; io_wdata = d; io_rd = rd; io_wr = wr;
        #5;
        check("R4 rdata", io_rdata, exp_rdata(a, rd, m_store));
        check("R8 rdata_en", {7'b0, io_rdata_en}, {7'b0, rd && a == PORT});
        check("R6 R7 req", {7'b0, sys_rst_req}, {7'b0, m_trig});
        @(posedge clk);
        #1;
        if (r) begin
            m_store = '0; m_trig = 1'b0;
        end else if (wr && a == PORT) begin
            if (d[2]) m_trig = 1'b1;
            else begin m_store = d & 8'h02; m_trig = 1'b0; end
        end else m_trig = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] exp);
        step(1'b0, PORT, 8'h00, 1'b1, 1'b0);
        check(tag, m_store, exp);
    endtask

    initial begin
        void'($urandom(32'd1234));
        step(1'b1, PORT, 8'hFF, 1'b0, 1'b1);
        step(1'b1, 16'h0000, 8'h00, 1'b0, 1'b0);
        // R5 reset state
        rd_chk("R5 reset value", 8'h00);
        // R2 trigger with all bits: pulse, value unchanged
        step(1'b0, PORT, 8'hFF, 1'b0, 1'b1);
        rd_chk("R2 trigger keeps value", 8'h00);
        // R3 store type bit
        step(1'b0, PORT, 8'h02, 1'b0, 1'b1);
        rd_chk("R3 type stored", 8'h02);
        step(1'b0, PORT, 8'hFB, 1'b0, 1'b1);
        rd_chk("R3 other bits dropped", 8'h02);
        // R1 near-miss addresses
        step(1'b0, 16'h0CF8, 8'h00, 1'b0, 1'b1);
        step(1'b0, 16'h0CFA, 8'h00, 1'b1, 1'b1);
        step(1'b0, 16'h1CF9, 8'h04, 1'b0, 1'b1);
        rd_chk("R1 other address ignored", 8'h02);
        // R2 trigger keeps stored type, R6 back-to-back pulses
        step(1'b0, PORT, 8'h04, 1'b0, 1'b1);
        step(1'b0, PORT, 8'h06, 1'b0, 1'b1);
        step(1'b0, PORT, 8'h00, 1'b1, 1'b0);
        check("R2 value after trigger", m_store, 8'h02);
        // R5 reset wins over write
        step(1'b1, PORT, 8'h02, 1'b0, 1'b1);
        rd_chk("R5 reset with write", 8'h00);
        step(1'b0, PORT, 8'h02, 1'b0, 1'b1);
        step(1'b1, PORT, 8'h04, 1'b0, 1'b1);
        rd_chk("R5 reset clears, no pulse", 8'h00);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            int sel;
            sel = int'($urandom_range(0, 9));
            a = (sel < 6) ? PORT : (sel < 8) ? PORT + 16'($urandom_range(0, 2)) - 16'd1
                                            : 16'($urandom());
            step(($urandom_range(0, 99) == 0), a, 8'($urandom()),
                 1'($urandom()), 1'($urandom()));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired R6 actual=hang expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule